// File: doc/BRIEF.md
# Flash Command Sequence Controller

This block sits behind the command port of a parallel NOR-style flash. It receives command writes as address/data pairs. It follows the multi-cycle unlock handshakes and turns them into operating modes: read array, autoselect, program, erase, erase-suspended, autoselect while suspended, and program while suspended. When a sequence completes, it sends a one-cycle start pulse to an external embedded-algorithm engine. The pulse carries the operation kind, the target address and the data.

The engine reports progress on a busy flag. The controller treats the busy high-to-low transition as completion. During an erase, the controller can suspend and resume the operation, and it remembers which sectors the suspended erase covers. A combinational select tells the read path when to return status instead of array data.

Sequences begin only from read array or from erase suspend. During an embedded operation, the controller ignores every write except a suspend request to a running erase. Autoselect is left only by the reset command.

Top module: `flash_cmd_fsm`

## Requirements
- R1: After synchronous reset the mode output is 0 (read array), op_start, susp_pulse and resume_pulse are low, and rd_status is low. The mode codes are: read array 0, autoselect 1, program 2, erase 3, erase suspended 4, autoselect in suspend 5, program in suspend 6.
- R2: An unlock is data AA at address 555, then data 55 at address 2AA. Only the low 11 address bits are compared. A third write at 555 then selects the command: A0 is program, 90 is autoselect, 80 is erase.
- R3: After the A0 cycle, the next write gives op_start for exactly one cycle, in the cycle after that write. With it come op_kind 0 and the write's address and data as op_addr/op_data. The mode becomes program (2), or 6 when the sequence started in erase suspend.
- R4: After 80, a second unlock pair followed by 10 at 555 starts a chip erase (op_kind 2). A second unlock pair followed by 30 at any address starts a sector erase (op_kind 1) of sector wr_addr[15:12]. The mode becomes erase (3). Erase is not accepted from erase suspend.
- R5: A write whose address or data does not fit the current step abandons the sequence without a start pulse. The mode stays read array, or stays erase suspend if the sequence began there.
- R6: Data F0 at any address aborts a sequence in progress. It also leaves autoselect: mode 1 returns to 0, and mode 5 returns to 4.
- R7: In modes 2, 3 and 6, every write other than B0 in mode 3 leaves the mode unchanged. This includes F0.
- R8: In autoselect (1 or 5), any write other than F0 leaves the mode unchanged.
- R9: B0 in erase mode enters mode 4 and pulses susp_pulse. 30 in mode 4 with no sequence in progress returns to mode 3 and pulses resume_pulse. B0 in any other mode produces no pulse.
- R10: A busy high-to-low transition ends the operation. Modes 2 and 3 go to 0, and mode 6 goes to 4. Busy falling in mode 4 has no effect.
- R11: rd_status is high in modes 2, 3 and 6. In mode 4 it is high only when rd_addr[15:12] is a sector of the suspended erase (all sectors for a chip erase). It is low in modes 0, 1 and 5.
- R12: When busy falls in the same cycle that B0 is written in erase mode, completion wins: the mode becomes 0 and no susp_pulse is produced.
- R13: Holding rst_n low for one clock returns to the R1 state from any mode and discards any partial unlock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-up reset |
| wr_en | input | 1 | One-cycle command write strobe |
| wr_addr | input | 16 | Command write address |
| wr_data | input | 8 | Command write data |
| eng_busy | input | 1 | Embedded engine busy flag |
| rd_addr | input | 16 | Current read address for the status select |
| mode_o | output | 3 | Current operating mode code |
| op_start | output | 1 | One-cycle operation start pulse |
| op_kind | output | 2 | 0 program, 1 sector erase, 2 chip erase |
| op_addr | output | 16 | Target address of the started operation |
| op_data | output | 8 | Data of the started operation |
| susp_pulse | output | 1 | Erase suspend request to the engine |
| resume_pulse | output | 1 | Erase resume request to the engine |
| rd_status | output | 1 | Reads return status instead of array data |

## Verification
Two functions can fall in the same cycle: completion of a running erase, seen as busy falling, and a suspend write. The bench provokes the overlap by dropping busy on exactly the clock edge that captures a B0 write. It then requires the mode to be read array, with susp_pulse low in the following cycle. A stale suspend would instead leave the controller parked in erase suspend with no operation to resume.

// File: rtl/flash_cmd_pkg.sv
// Shared types for the flash command controller: mode codes, operation
// kinds, unlock-sequence steps, command bytes and the decoded event bundle.
package flash_cmd_pkg;

    typedef enum logic [2:0] {
        MD_READ      = 3'd0,
        MD_AUTO      = 3'd1,
        MD_PROG      = 3'd2,
        MD_ERASE     = 3'd3,
        MD_SUSP      = 3'd4,
        MD_SUSP_AUTO = 3'd5,
        MD_SUSP_PROG = 3'd6
    } mode_e;

    typedef enum logic [1:0] {
        OK_PROG = 2'd0,
        OK_SECT = 2'd1,
        OK_CHIP = 2'd2
    } opkind_e;

    typedef enum logic [2:0] {
        SQ_IDLE, SQ_U1, SQ_U2, SQ_PDATA, SQ_E1, SQ_E2, SQ_E3
    } seq_e;

    localparam logic [7:0] CMD_KEY1   = 8'hAA;
    localparam logic [7:0] CMD_KEY2   = 8'h55;
    localparam logic [7:0] CMD_PROG   = 8'hA0;
    localparam logic [7:0] CMD_AUTO   = 8'h90;
    localparam logic [7:0] CMD_ERASE  = 8'h80;
    localparam logic [7:0] CMD_CHIP   = 8'h10;
    localparam logic [7:0] CMD_SECT   = 8'h30;
    localparam logic [7:0] CMD_RESET  = 8'hF0;
    localparam logic [7:0] CMD_SUSP   = 8'hB0;
    localparam logic [7:0] CMD_RESUME = 8'h30;

    typedef struct packed {
        logic prog;
        logic autosel;
        logic sect;
        logic chip;
        logic rst;
        logic susp;
        logic resume;
    } evt_t;

endpackage

// File: rtl/fcs_seq_tracker.sv
// Unlock-sequence tracker. Follows the address/data handshake of command
// writes and emits one decoded event per completed command.
// Assumes: mode_i is the registered mode; sequences only run in read array
// or erase suspend, and any write in another mode returns the step to idle.
module fcs_seq_tracker
    import flash_cmd_pkg::*;
#(
    parameter int AW    = 16,
    parameter int DW    = 8,
    parameter int CMP_W = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  mode_e         mode_i,
    output evt_t          ev_o
);
    localparam logic [CMP_W-1:0] ADDR_A = CMP_W'('h555);
    localparam logic [CMP_W-1:0] ADDR_B = CMP_W'('h2AA);

    seq_e seq_q, seq_d;
    evt_t ev;
    logic at_a, at_b, base;

    assign at_a = (wr_addr[CMP_W-1:0] == ADDR_A);
    assign at_b = (wr_addr[CMP_W-1:0] == ADDR_B);
    assign base = (mode_i == MD_READ) || (mode_i == MD_SUSP);

    // Next step and command events from the current write.
    always_comb begin
        seq_d = seq_q;
        ev    = '0;
        if (wr_en) begin
            seq_d = SQ_IDLE;
            if (!base) begin
                if (wr_data == CMD_RESET &&
                    (mode_i == MD_AUTO || mode_i == MD_SUSP_AUTO)) ev.rst = 1'b1;
                if (wr_data == CMD_SUSP && mode_i == MD_ERASE) ev.susp = 1'b1;
            end else if (wr_data == CMD_RESET) begin
                ev.rst = 1'b1;
            end else begin
                case (seq_q)
                    SQ_IDLE: begin
                        if (at_a && wr_data == CMD_KEY1) seq_d = SQ_U1;
                        else if (mode_i == MD_SUSP && wr_data == CMD_RESUME) ev.resume = 1'b1;
                    end
                    SQ_U1: if (at_b && wr_data == CMD_KEY2) seq_d = SQ_U2;
                    SQ_U2: begin
                        if (at_a) begin
                            if (wr_data == CMD_PROG) seq_d = SQ_PDATA;
                            else if (wr_data == CMD_AUTO) ev.autosel = 1'b1;
                            else if (wr_data == CMD_ERASE && mode_i == MD_READ) seq_d = SQ_E1;
                        end
                    end
                    SQ_PDATA: ev.prog = 1'b1;
                    SQ_E1: if (at_a && wr_data == CMD_KEY1) seq_d = SQ_E2;
                    SQ_E2: if (at_b && wr_data == CMD_KEY2) seq_d = SQ_E3;
                    SQ_E3: begin
                        if (at_a && wr_data == CMD_CHIP) ev.chip = 1'b1;
                        else if (wr_data == CMD_SECT) ev.sect = 1'b1;
                    end
                    default: seq_d = SQ_IDLE;
                endcase
            end
        end
    end

    // Step register.
    always_ff @(posedge clk) begin
        if (!rst_n) seq_q <= SQ_IDLE;
        else        seq_q <= seq_d;
    end

    assign ev_o = ev;

    AST_SEQ_IDLE_OUTSIDE_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        !base |-> seq_q == SQ_IDLE); // R7

endmodule

// File: rtl/fcs_sector_mask.sv
// Records which sectors a started erase covers, so that reads during erase
// suspend can be steered to status for those sectors only.
// Assumes: erase starts arrive only from read array; clear marks the end of
// the erase.
module fcs_sector_mask
    import flash_cmd_pkg::*;
#(
    parameter int AW     = 16,
    parameter int SECT_W = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set_sect,
    input  logic          set_all,
    input  logic [AW-1:0] set_addr,
    input  logic          clear,
    input  logic [AW-1:0] rd_addr,
    input  mode_e         mode_i,
    output logic          hit_o
);
    localparam int NSECT = 1 << SECT_W;

    logic [NSECT-1:0] mask_q;
    logic [SECT_W-1:0] set_idx, rd_idx;

    assign set_idx = set_addr[AW-1 -: SECT_W];
    assign rd_idx  = rd_addr[AW-1 -: SECT_W];

    // One flag per sector, set on erase start, cleared at erase end.
    for (genvar s = 0; s < NSECT; s++) begin : g_sect
        always_ff @(posedge clk) begin
            if (!rst_n || clear)                                  mask_q[s] <= 1'b0;
            else if (set_all || (set_sect && set_idx == SECT_W'(s))) mask_q[s] <= 1'b1;
        end
    end

    assign hit_o = mask_q[rd_idx];

    AST_MASK_EMPTY_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MD_READ || mode_i == MD_AUTO || mode_i == MD_PROG) |-> mask_q == '0); // R11

endmodule

// File: rtl/fcs_mode_ctrl.sv
// Mode register and engine interface. Applies decoded events and engine
// completion to the mode, and registers the start/suspend/resume pulses.
// Assumes: the engine signals completion by dropping busy after holding it.
module fcs_mode_ctrl
    import flash_cmd_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  evt_t          ev_i,
    input  logic          eng_busy,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    output mode_e         mode_o,
    output logic          op_start,
    output opkind_e       op_kind,
    output logic [AW-1:0] op_addr,
    output logic [DW-1:0] op_data,
    output logic          susp_pulse,
    output logic          resume_pulse,
    output logic          erase_done
);
    mode_e mode_q, mode_d;
    logic  busy_q, done, start_d;

    assign done    = busy_q && !eng_busy;
    assign start_d = ev_i.prog || ev_i.sect || ev_i.chip;
    assign erase_done = (mode_q == MD_ERASE) && done;

    // Mode transitions; completion outranks a suspend in the same cycle.
    always_comb begin
        mode_d = mode_q;
        case (mode_q)
            MD_READ: begin
                if (ev_i.prog)                     mode_d = MD_PROG;
                else if (ev_i.autosel)             mode_d = MD_AUTO;
                else if (ev_i.sect || ev_i.chip)   mode_d = MD_ERASE;
            end
            MD_AUTO:      if (ev_i.rst) mode_d = MD_READ;
            MD_PROG:      if (done)     mode_d = MD_READ;
            MD_ERASE: begin
                if (done)           mode_d = MD_READ;
                else if (ev_i.susp) mode_d = MD_SUSP;
            end
            MD_SUSP: begin
                if (ev_i.prog)         mode_d = MD_SUSP_PROG;
                else if (ev_i.autosel) mode_d = MD_SUSP_AUTO;
                else if (ev_i.resume)  mode_d = MD_ERASE;
            end
            MD_SUSP_AUTO: if (ev_i.rst) mode_d = MD_SUSP;
            MD_SUSP_PROG: if (done)     mode_d = MD_SUSP;
            default:      mode_d = MD_READ;
        endcase
    end

    // Mode, busy history and one-cycle pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q       <= MD_READ;
            busy_q       <= 1'b0;
            op_start     <= 1'b0;
            susp_pulse   <= 1'b0;
            resume_pulse <= 1'b0;
        end else begin
            mode_q       <= mode_d;
            busy_q       <= eng_busy;
            op_start     <= start_d;
            susp_pulse   <= (mode_q == MD_ERASE) && ev_i.susp && !done;
            resume_pulse <= (mode_q == MD_SUSP) && ev_i.resume;
        end
    end

    // Operation descriptor captured with each start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_kind <= OK_PROG;
            op_addr <= '0;
            op_data <= '0;
        end else if (start_d) begin
            op_kind <= ev_i.prog ? OK_PROG : (ev_i.sect ? OK_SECT : OK_CHIP);
            op_addr <= wr_addr;
            op_data <= wr_data;
        end
    end

    assign mode_o = mode_q;

    AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        op_start |=> !op_start); // R3
    AST_AUTO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MD_AUTO && !ev_i.rst) |=> mode_q == MD_AUTO); // R8
    AST_DONE_BEATS_SUSPEND: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MD_ERASE && busy_q && !eng_busy) |=> (mode_q == MD_READ && !susp_pulse)); // R12
    AST_SUSP_PULSE_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        susp_pulse |-> mode_q == MD_SUSP); // R9

endmodule

// File: rtl/flash_cmd_fsm.sv
// Top of the flash command controller: sequence tracker, mode control and
// suspended-sector memory, plus the read status select.
// Assumes: one command write per wr_en cycle; engine busy follows op_start.
module flash_cmd_fsm
    import flash_cmd_pkg::*;
#(
    parameter int AW     = 16,
    parameter int DW     = 8,
    parameter int CMP_W  = 11,
    parameter int SECT_W = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          eng_busy,
    input  logic [AW-1:0] rd_addr,
    output logic [2:0]    mode_o,
    output logic          op_start,
    output logic [1:0]    op_kind,
    output logic [AW-1:0] op_addr,
    output logic [DW-1:0] op_data,
    output logic          susp_pulse,
    output logic          resume_pulse,
    output logic          rd_status
);
    evt_t    ev;
    mode_e   mode;
    opkind_e kind;
    logic    erase_done, sect_hit, busy_mode;

    fcs_seq_tracker #(.AW(AW), .DW(DW), .CMP_W(CMP_W)) u_track (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .mode_i(mode), .ev_o(ev)
    );

    fcs_mode_ctrl #(.AW(AW), .DW(DW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .ev_i(ev), .eng_busy(eng_busy),
        .wr_addr(wr_addr), .wr_data(wr_data), .mode_o(mode),
        .op_start(op_start), .op_kind(kind), .op_addr(op_addr),
        .op_data(op_data), .susp_pulse(susp_pulse),
        .resume_pulse(resume_pulse), .erase_done(erase_done)
    );

    fcs_sector_mask #(.AW(AW), .SECT_W(SECT_W)) u_mask (
        .clk(clk), .rst_n(rst_n), .set_sect(ev.sect), .set_all(ev.chip),
        .set_addr(wr_addr), .clear(erase_done), .rd_addr(rd_addr),
        .mode_i(mode), .hit_o(sect_hit)
    );

    // Status select for the read path.
    assign busy_mode = (mode == MD_PROG) || (mode == MD_ERASE) || (mode == MD_SUSP_PROG);
    assign rd_status = busy_mode || (mode == MD_SUSP && sect_hit);
    assign mode_o    = mode;
    assign op_kind   = kind;

    AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 3'd2 && wr_en && eng_busy) |=> mode_o == 3'd2); // R7
    AST_RESET_STATE: assert property (@(posedge clk)
        !rst_n |=> (mode_o == 3'd0 && !op_start && !susp_pulse)); // R13

endmodule

// File: tb/flash_cmd_fsm_tb_top.sv
`timescale 1ns/1ps
module flash_cmd_fsm_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        eng_busy = 1'b0;
    logic [15:0] rd_addr = '0;
    logic [2:0]  mode_o;
    logic        op_start;
    logic [1:0]  op_kind;
    logic [15:0] op_addr;
    logic [7:0]  op_data;
    logic        susp_pulse, resume_pulse, rd_status;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    flash_cmd_fsm dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .eng_busy(eng_busy), .rd_addr(rd_addr),
        .mode_o(mode_o), .op_start(op_start), .op_kind(op_kind),
        .op_addr(op_addr), .op_data(op_data), .susp_pulse(susp_pulse),
        .resume_pulse(resume_pulse), .rd_status(rd_status)
    );

    // Vector: {run engine first, address, data, expected mode, expected start}
    localparam int NV = 43;
    localparam logic [28:0] VEC [0:NV-1] = '{
        {1'b0,16'h0555,8'hAA,3'd0,1'b0}, // R2 unlock 1
        {1'b0,16'h02AA,8'h55,3'd0,1'b0},
        {1'b0,16'h0555,8'h90,3'd1,1'b0}, // R2 autoselect
        {1'b0,16'h0123,8'hAA,3'd1,1'b0}, // R8 stays
        {1'b0,16'h0777,8'hF0,3'd0,1'b0}, // R6 reset, any address
        {1'b0,16'h0555,8'hAA,3'd0,1'b0},
        {1'b0,16'h02AA,8'h55,3'd0,1'b0},
        {1'b0,16'h0555,8'hA0,3'd0,1'b0},
        {1'b0,16'h1234,8'h5A,3'd2,1'b1}, // R3 program start
        {1'b0,16'h0000,8'hF0,3'd2,1'b0}, // R7 reset ignored
        {1'b1,16'h0555,8'hAA,3'd0,1'b0}, // R10 completion
        {1'b0,16'h02AA,8'h55,3'd0,1'b0},
        {1'b0,16'h0555,8'h80,3'd0,1'b0},
        {1'b0,16'h0555,8'hAA,3'd0,1'b0},
        {1'b0,16'h02AA,8'h55,3'd0,1'b0},
        {1'b0,16'h5000,8'h30,3'd3,1'b1}, // R4 sector erase
        {1'b0,16'h0000,8'hF0,3'd3,1'b0}, // R7
        {1'b0,16'h0000,8'hB0,3'd4,1'b0}, // R9 suspend
        {1'b0,16'h0555,8'hAA,3'd4,1'b0},
        {1'b0,16'h02AA,8'h55,3'd4,1'b0},
        {1'b0,16'h0555,8'hA0,3'd4,1'b0},
        {1'b0,16'h1000,8'h33,3'd6,1'b1}, // R3 program in suspend
        {1'b1,16'h0000,8'h30,3'd3,1'b0}, // R10 back to 4, R9 resume
        {1'b1,16'h0555,8'hAA,3'd0,1'b0}, // R10
        {1'b0,16'h02AA,8'h56,3'd0,1'b0}, // R5 wrong data
        {1'b0,16'h0555,8'hA0,3'd0,1'b0}, // R5 no unlock held
        {1'b0,16'h0555,8'hAA,3'd0,1'b0},
        {1'b0,16'h02AA,8'h55,3'd0,1'b0},
        {1'b0,16'h0555,8'hF0,3'd0,1'b0}, // R6 abort
        {1'b0,16'h0555,8'hA0,3'd0,1'b0},
        {1'b0,16'h0555,8'hAA,3'd0,1'b0},
        {1'b0,16'h02AA,8'h55,3'd0,1'b0},
        {1'b0,16'h0555,8'h80,3'd0,1'b0},
        {1'b0,16'h0555,8'hAA,3'd0,1'b0},
        {1'b0,16'h0000,8'hF0,3'd0,1'b0}, // R6 abort erase
        {1'b0,16'h02AA,8'h55,3'd0,1'b0},
        {1'b0,16'h0555,8'h10,3'd0,1'b0},
        {1'b0,16'h0555,8'hAA,3'd0,1'b0},
        {1'b0,16'h02AA,8'h55,3'd0,1'b0},
        {1'b0,16'h0555,8'h80,3'd0,1'b0},
        {1'b0,16'h0555,8'hAA,3'd0,1'b0},
        {1'b0,16'h02AA,8'h55,3'd0,1'b0},
        {1'b0,16'h0555,8'h10,3'd3,1'b1}  // R4 chip erase
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Engine stub: busy for n cycles, then release and let completion land.
    task automatic run_engine(input int n);
        @(negedge clk);
        eng_busy = 1'b1;
        for (int i = 0; i < n; i++) @(negedge clk);
        eng_busy = 1'b0;
        @(negedge clk);
    endtask

    task automatic unlock3(input logic [7:0] cmd);
        wr(16'h0555, 8'hAA);
        wr(16'h02AA, 8'h55);
        wr(16'h0555, cmd);
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL R13 watchdog: act=timeout exp=finish");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 mode", mode_o, 0);
        chk("R1 op_start", op_start, 0);
        chk("R1 rd_status", rd_status, 0);
        chk("R1 pulses", {susp_pulse, resume_pulse}, 0);

        // Table walk: R2 R3 R4 R5 R6 R7 R8 R9 R10
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][28]) run_engine(3);
            wr(VEC[i][27:12], VEC[i][11:4]);
            chk($sformatf("R2 R5 vector %0d mode", i), mode_o, VEC[i][3:1]);
            chk($sformatf("R3 R4 vector %0d start", i), op_start, VEC[i][0]);
        end

        // Chip erase running: suspend, status everywhere (R11)
        chk("R4 chip kind", op_kind, 2);
        wr(16'h0000, 8'hB0);
        chk("R9 suspend pulse", susp_pulse, 1);
        rd_addr = 16'hF000;
        #0.1 chk("R11 chip-suspended status", rd_status, 1);
        unlock3(8'h90);
        chk("R6 autoselect in suspend", mode_o, 5);
        chk("R11 status off in autoselect", rd_status, 0);
        wr(16'h0555, 8'hAA);
        chk("R8 suspend autoselect held", mode_o, 5);
        wr(16'h0000, 8'hF0);
        chk("R6 exit to suspend", mode_o, 4);
        wr(16'h0000, 8'hB0);
        chk("R9 no pulse in suspend", susp_pulse, 0);
        @(negedge clk) eng_busy = 1'b1;
        @(negedge clk) eng_busy = 1'b0;
        @(negedge clk);
        chk("R10 busy fall in suspend ignored", mode_o, 4);
        wr(16'h0000, 8'h30);
        chk("R9 resume mode", mode_o, 3);
        chk("R9 resume pulse", resume_pulse, 1);
        run_engine(4);
        chk("R10 erase done", mode_o, 0);
        chk("R11 read array no status", rd_status, 0);

        // Sector erase, per-sector status, collision (R4 R11 R12)
        unlock3(8'h80);
        wr(16'h0555, 8'hAA);
        wr(16'h02AA, 8'h55);
        wr(16'h5ABC, 8'h30);
        chk("R4 sector kind", op_kind, 1);
        chk("R4 sector addr", op_addr, 16'h5ABC);
        wr(16'h0000, 8'hB0);
        rd_addr = 16'h5010;
        #0.1 chk("R11 suspended sector status", rd_status, 1);
        rd_addr = 16'h2010;
        #0.1 chk("R11 other sector array", rd_status, 0);
        unlock3(8'h80);
        chk("R4 no erase from suspend", mode_o, 4);
        wr(16'h0000, 8'h30);
        chk("R9 resume after bad erase", mode_o, 3);
        @(negedge clk) eng_busy = 1'b1;
        repeat (3) @(negedge clk);
        eng_busy = 1'b0;
        wr_en = 1'b1; wr_addr = 16'h0000; wr_data = 8'hB0;
        @(negedge clk);
        wr_en = 1'b0;
        chk("R12 completion wins mode", mode_o, 0);
        chk("R12 no suspend pulse", susp_pulse, 0);

        // Program descriptor, suspend ignored, power-up reset (R3 R9 R13)
        unlock3(8'hA0);
        wr(16'h0ABC, 8'h3C);
        chk("R3 kind", op_kind, 0);
        chk("R3 addr", op_addr, 16'h0ABC);
        chk("R3 data", op_data, 8'h3C);
        chk("R11 status while programming", rd_status, 1);
        wr(16'h0000, 8'hB0);
        chk("R9 B0 in program mode", mode_o, 2);
        chk("R9 B0 in program pulse", susp_pulse, 0);
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        chk("R13 reset from program", mode_o, 0);
        wr(16'h0555, 8'hAA);
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        wr(16'h02AA, 8'h55);
        wr(16'h0555, 8'hA0);
        wr(16'h0100, 8'h11);
        chk("R13 partial unlock discarded mode", mode_o, 0);
        chk("R13 partial unlock no start", op_start, 0);

        report();
    end
endmodule